// File: doc/BRIEF.md
# Write-Back Line Cache with Flush Sweep

This block is a direct-mapped data cache that sits between a single processor and a word-addressed shared memory. Stores land only in the cache; a line whose contents differ from memory is copied back only when its slot is needed for another address, or when software asks for a sweep. A sweep visits every slot in ascending index order and copies each modified line back. It then bumps a serial counter, so software can tell that memory has become current since a given point.

A second request port serves a DMA channel. Device-bound reads see modified data that is still in the cache. Device-sourced writes go straight to memory and drop any cached copy of that line. A per-access uncached flag sends a processor access directly to memory without allocating a slot. The processor, DMA and sweep ports each use a level request that is held until a one-cycle acknowledge. The memory port holds its request until the memory returns a one-cycle ready.

Top module: `cwb_cache`

## Requirements
- R1: During and right after reset, cpu_busy, cpu_ack, dma_ack, sweep_done and mem_req are 0, sweep_serial is 0, and every slot is empty.
- R2: A cached processor write changes only the cache. Memory stays unchanged until that line is copied back.
- R3: A cached processor read returns the most recent value written to that word.
- R4: A miss reads the whole 4-word line containing the word: four memory reads at line base, base+1, base+2, base+3 in that order. Later accesses to that line make no memory request. The memory request, address and direction stay stable until mem_ready.
- R5: The word address splits as offset = bits [OFFS_W-1:0], index = the next INDEX_W bits, and tag = the rest. A miss on a slot that holds a modified line first writes that line's four words to memory, in ascending order, and then refills the slot.
- R6: A miss on a slot that holds an unmodified line refills it without writing anything to memory.
- R7: A sweep writes every modified line to memory in ascending index order, with ascending words inside each line. On completion, sweep_done pulses and sweep_serial rises by exactly one; at that moment no line is modified. sweep_serial changes at no other time.
- R8: A sweep leaves its lines valid and unmodified. A second sweep with no intervening stores writes nothing, and reads of swept lines still hit.
- R9: A DMA read (dma_we=0) of a word whose line is cached and modified returns the cached value with no memory access. Otherwise it reads memory.
- R10: A DMA write (dma_we=1) writes memory and invalidates a cached line holding that address, dropping its modified contents. A later processor read refetches the line from memory.
- R11: A processor access with cpu_uncached=1 performs exactly one memory access at its address and leaves the cache slots unchanged.
- R12: cpu_busy is 1 from the cycle after a request is taken until its acknowledge. At most one of cpu_ack, dma_ack and sweep_done pulses in any cycle, and only while cpu_busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_uncached | input | 1 | Bypass the cache for this access |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ack |
| cpu_ack | output | 1 | One-cycle completion of a processor access |
| cpu_busy | output | 1 | Controller is working on a request |
| dma_req | input | 1 | DMA request, held until dma_ack |
| dma_we | input | 1 | 1 = device-to-memory write, 0 = memory-to-device read |
| dma_addr | input | ADDR_W | DMA word address |
| dma_wdata | input | DATA_W | DMA write data |
| dma_rdata | output | DATA_W | DMA read data, valid with dma_ack |
| dma_ack | output | 1 | One-cycle completion of a DMA access |
| sweep_req | input | 1 | Sweep request, held until sweep_done |
| sweep_done | output | 1 | One-cycle sweep completion |
| sweep_serial | output | SERIAL_W | Count of completed sweeps |
| mem_req | output | 1 | Memory request, held until mem_ready |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | One-cycle memory completion |

## Verification
A wrong tag, valid or modified flag does not show at once. It shows when the slot is next touched. A false hit returns stale data on the next load. A lost modified flag leaves memory stale after the next sweep or eviction. A modified flag that should have been cleared shows as extra write-back traffic on a second sweep. The bench therefore counts every memory read and write, logs their addresses, and follows each store with reads, sweeps and conflicting accesses that force the corrupted state out to the ports within a few requests.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_REDO, S_WB_RD, S_WB_LD, S_WB_WT,
    S_FILL_RQ, S_FILL_WT, S_EXT_WT, S_SW_RD, S_SW_CHK, S_SW_NXT
  } cwb_state_e;

  typedef enum logic [2:0] {
    OP_CRD, OP_CWR, OP_DRD, OP_DWR, OP_SWP
  } cwb_op_e;
endpackage

// File: rtl/cwb_data.sv
module cwb_data #(
  parameter int AW = 11,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ram [DEPTH];

  // single port, read-first: suits block RAM inference
  always_ff @(posedge clk) begin
    if (we) ram[addr] <= wdata;
    rdata <= ram[addr];
  end
endmodule

// File: rtl/cwb_tags.sv
module cwb_tags #(
  parameter int INDEX_W = 9,
  parameter int TAG_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INDEX_W-1:0] idx,
  input  logic               fill_en,
  input  logic [TAG_W-1:0]   fill_tag,
  input  logic               dirty_set,
  input  logic               dirty_clr,
  input  logic               inval_en,
  output logic [TAG_W-1:0]   tag_q,
  output logic               line_valid,
  output logic               line_dirty,
  output logic [(1<<INDEX_W)-1:0] dirty_vec
);
  localparam int LINES = 1 << INDEX_W;

  logic [TAG_W-1:0] tag_ram [LINES];
  logic [LINES-1:0] valid_r, dirty_r;

  always_ff @(posedge clk) begin
    if (fill_en) tag_ram[idx] <= fill_tag;
    tag_q <= tag_ram[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_r <= '0;
      dirty_r <= '0;
    end else begin
      if (fill_en) begin
        valid_r[idx] <= 1'b1;
        dirty_r[idx] <= 1'b0;
      end
      if (dirty_set) dirty_r[idx] <= 1'b1;
      if (dirty_clr) dirty_r[idx] <= 1'b0;
      if (inval_en) begin
        valid_r[idx] <= 1'b0;
        dirty_r[idx] <= 1'b0;
      end
    end
  end

  assign line_valid = valid_r[idx];
  assign line_dirty = dirty_r[idx];
  assign dirty_vec  = dirty_r;

  // R10: a slot only becomes modified while it is valid
  a_r10_dirty_needs_valid: assert property (@(posedge clk) disable iff (rst)
    dirty_set |-> line_valid);
endmodule

// File: rtl/cwb_cache.sv
module cwb_cache #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 36,
  parameter int INDEX_W  = 9,
  parameter int OFFS_W   = 2,
  parameter int SERIAL_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic                cpu_uncached,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                cpu_ack,
  output logic                cpu_busy,
  input  logic                dma_req,
  input  logic                dma_we,
  input  logic [ADDR_W-1:0]   dma_addr,
  input  logic [DATA_W-1:0]   dma_wdata,
  output logic [DATA_W-1:0]   dma_rdata,
  output logic                dma_ack,
  input  logic                sweep_req,
  output logic                sweep_done,
  output logic [SERIAL_W-1:0] sweep_serial,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_ready
);
  import cwb_pkg::*;

  localparam int TAG_W   = ADDR_W - INDEX_W - OFFS_W;
  localparam int SLOT_AW = INDEX_W + OFFS_W;
  localparam logic [OFFS_W-1:0]  LAST_OFF = '1;
  localparam logic [INDEX_W-1:0] LAST_IDX = '1;

  cwb_state_e state;
  cwb_op_e    op;
  logic [TAG_W-1:0]   req_tag, wb_tag;
  logic [OFFS_W-1:0]  req_off, cnt;
  logic [INDEX_W-1:0] cur_idx;
  logic [DATA_W-1:0]  req_wdata;

  logic [ADDR_W-1:0]  sel_addr;
  logic [INDEX_W-1:0] t_idx;
  logic [SLOT_AW-1:0] d_addr;
  logic               d_we;
  logic [DATA_W-1:0]  d_wd, d_q;
  logic [TAG_W-1:0]   tag_q;
  logic               line_valid, line_dirty, hit;
  logic               fill_en, dirty_set, dirty_clr, inval_en;
  logic [(1<<INDEX_W)-1:0] dirty_vec;

  assign sel_addr = dma_req ? dma_addr : cpu_addr;
  assign t_idx    = (state == S_IDLE) ? sel_addr[OFFS_W +: INDEX_W] : cur_idx;
  assign hit      = line_valid && (tag_q == req_tag);

  assign fill_en   = (state == S_FILL_WT) && mem_ready && (cnt == LAST_OFF);
  assign dirty_set = (state == S_LOOK) && (op == OP_CWR) && hit;
  assign dirty_clr = (state == S_WB_WT) && mem_ready && (cnt == LAST_OFF) && (op == OP_SWP);
  assign inval_en  = (state == S_LOOK) && (op == OP_DWR) && hit;

  always_comb begin
    d_addr = {cur_idx, req_off};
    d_we   = 1'b0;
    d_wd   = req_wdata;
    case (state)
      S_IDLE:           d_addr = sel_addr[SLOT_AW-1:0];
      S_LOOK:           d_we   = dirty_set;
      S_WB_RD, S_WB_LD: d_addr = {cur_idx, cnt};
      S_FILL_WT: begin
        d_addr = {cur_idx, cnt};
        d_we   = mem_ready;
        d_wd   = mem_rdata;
      end
      default: ;
    endcase
  end

  cwb_tags #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .idx(t_idx), .fill_en(fill_en), .fill_tag(req_tag),
    .dirty_set(dirty_set), .dirty_clr(dirty_clr), .inval_en(inval_en),
    .tag_q(tag_q), .line_valid(line_valid), .line_dirty(line_dirty),
    .dirty_vec(dirty_vec));

  cwb_data #(.AW(SLOT_AW), .DW(DATA_W)) u_data (
    .clk(clk), .we(d_we), .addr(d_addr), .wdata(d_wd), .rdata(d_q));

  assign cpu_busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      op           <= OP_CRD;
      req_tag      <= '0;
      req_off      <= '0;
      cur_idx      <= '0;
      req_wdata    <= '0;
      wb_tag       <= '0;
      cnt          <= '0;
      cpu_rdata    <= '0;
      dma_rdata    <= '0;
      cpu_ack      <= 1'b0;
      dma_ack      <= 1'b0;
      sweep_done   <= 1'b0;
      sweep_serial <= '0;
      mem_req      <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
    end else begin
      cpu_ack    <= 1'b0;
      dma_ack    <= 1'b0;
      sweep_done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (dma_req) begin
            op        <= dma_we ? OP_DWR : OP_DRD;
            req_tag   <= dma_addr[ADDR_W-1 -: TAG_W];
            cur_idx   <= dma_addr[OFFS_W +: INDEX_W];
            req_off   <= dma_addr[OFFS_W-1:0];
            req_wdata <= dma_wdata;
            state     <= S_LOOK;
          end else if (sweep_req) begin
            op      <= OP_SWP;
            cur_idx <= '0;
            state   <= S_SW_RD;
          end else if (cpu_req) begin
            op        <= cpu_we ? OP_CWR : OP_CRD;
            req_tag   <= cpu_addr[ADDR_W-1 -: TAG_W];
            cur_idx   <= cpu_addr[OFFS_W +: INDEX_W];
            req_off   <= cpu_addr[OFFS_W-1:0];
            req_wdata <= cpu_wdata;
            if (cpu_uncached) begin
              mem_req   <= 1'b1;
              mem_we    <= cpu_we;
              mem_addr  <= cpu_addr;
              mem_wdata <= cpu_wdata;
              state     <= S_EXT_WT;
            end else begin
              state <= S_LOOK;
            end
          end
        end
        S_LOOK: begin
          case (op)
            OP_CRD, OP_CWR: begin
              if (hit) begin
                if (op == OP_CRD) cpu_rdata <= d_q;
                cpu_ack <= 1'b1;
                state   <= S_IDLE;
              end else begin
                cnt    <= '0;
                wb_tag <= tag_q;
                state  <= (line_valid && line_dirty) ? S_WB_RD : S_FILL_RQ;
              end
            end
            OP_DRD: begin
              if (hit && line_dirty) begin
                dma_rdata <= d_q;
                dma_ack   <= 1'b1;
                state     <= S_IDLE;
              end else begin
                mem_req  <= 1'b1;
                mem_we   <= 1'b0;
                mem_addr <= {req_tag, cur_idx, req_off};
                state    <= S_EXT_WT;
              end
            end
            default: begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= {req_tag, cur_idx, req_off};
              mem_wdata <= req_wdata;
              state     <= S_EXT_WT;
            end
          endcase
        end
        S_REDO:  state <= S_LOOK;
        S_WB_RD: state <= S_WB_LD;
        S_WB_LD: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= {wb_tag, cur_idx, cnt};
          mem_wdata <= d_q;
          state     <= S_WB_WT;
        end
        S_WB_WT: if (mem_ready) begin
          mem_req <= 1'b0;
          cnt     <= cnt + 1'b1;
          if (cnt != LAST_OFF)     state <= S_WB_RD;
          else if (op == OP_SWP)   state <= S_SW_NXT;
          else                     state <= S_FILL_RQ;
        end
        S_FILL_RQ: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= {req_tag, cur_idx, cnt};
          state    <= S_FILL_WT;
        end
        S_FILL_WT: if (mem_ready) begin
          mem_req <= 1'b0;
          cnt     <= cnt + 1'b1;
          state   <= (cnt == LAST_OFF) ? S_REDO : S_FILL_RQ;
        end
        S_EXT_WT: if (mem_ready) begin
          mem_req <= 1'b0;
          if (op == OP_DRD || op == OP_DWR) begin
            dma_rdata <= mem_rdata;
            dma_ack   <= 1'b1;
          end else begin
            cpu_rdata <= mem_rdata;
            cpu_ack   <= 1'b1;
          end
          state <= S_IDLE;
        end
        S_SW_RD: state <= S_SW_CHK;
        S_SW_CHK: begin
          if (line_valid && line_dirty) begin
            wb_tag <= tag_q;
            cnt    <= '0;
            state  <= S_WB_RD;
          end else begin
            state <= S_SW_NXT;
          end
        end
        S_SW_NXT: begin
          if (cur_idx == LAST_IDX) begin
            sweep_serial <= sweep_serial + 1'b1;
            sweep_done   <= 1'b1;
            state        <= S_IDLE;
          end else begin
            cur_idx <= cur_idx + 1'b1;
            state   <= S_SW_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R12: completions are exclusive and only seen once the controller is idle
  a_r12_single_ack: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_ack, dma_ack, sweep_done}));
  a_r12_ack_idle: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack || dma_ack || sweep_done) |-> !cpu_busy);
  // R7: serial steps by one exactly at sweep completion, with nothing left modified
  a_r7_serial_step: assert property (@(posedge clk) disable iff (rst)
    sweep_done |-> sweep_serial == $past(sweep_serial) + SERIAL_W'(1));
  a_r7_serial_hold: assert property (@(posedge clk) disable iff (rst)
    !sweep_done |-> $stable(sweep_serial));
  a_r7_all_clean: assert property (@(posedge clk) disable iff (rst)
    sweep_done |-> dirty_vec == '0);
  // R4: memory request held stable until ready
  a_r4_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: tb/sim_cwb_cache.sv
module sim_cwb_cache;
  localparam int AW = 8;
  localparam int DW = 36;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          cpu_req = 0, cpu_we = 0, cpu_unc = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic          cpu_ack, cpu_busy;
  logic          dma_req = 0, dma_we = 0;
  logic [AW-1:0] dma_addr = '0;
  logic [DW-1:0] dma_wdata = '0, dma_rdata;
  logic          dma_ack;
  logic          sweep_req = 0, sweep_done;
  logic [SW-1:0] sweep_serial;
  logic          mem_req, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  cwb_cache #(.ADDR_W(AW), .DATA_W(DW), .INDEX_W(3), .OFFS_W(2), .SERIAL_W(SW)) u0 (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_uncached(cpu_unc), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .cpu_busy(cpu_busy),
    .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .dma_rdata(dma_rdata), .dma_ack(dma_ack),
    .sweep_req(sweep_req), .sweep_done(sweep_done), .sweep_serial(sweep_serial),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready));

  function automatic logic [DW-1:0] f0(int a);
    return DW'(a * 37 + 1000);
  endfunction
  function automatic logic [DW-1:0] fw(int a);
    return 36'h9_0000_0000 | DW'(a * 3 + 5);
  endfunction

  // memory model: one-cycle ready, logs traffic
  logic [DW-1:0] mm [256];
  int rlog [1024];
  int wlog [1024];
  int rd_n, wr_n;
  always @(posedge clk) begin
    if (rst) begin
      mem_ready <= 1'b0;
      mem_rdata <= '0;
      rd_n <= 0;
      wr_n <= 0;
      for (int i = 0; i < 256; i++) mm[i] <= f0(i);
    end else begin
      mem_ready <= 1'b0;
      if (mem_req && !mem_ready) begin
        mem_ready <= 1'b1;
        if (mem_we) begin
          mm[mem_addr] <= mem_wdata;
          wlog[wr_n % 1024] <= int'(mem_addr);
          wr_n <= wr_n + 1;
        end else begin
          mem_rdata <= mm[mem_addr];
          rlog[rd_n % 1024] <= int'(mem_addr);
          rd_n <= rd_n + 1;
        end
      end
    end
  end

  int nchk = 0, nfail = 0;
  int rd0, wr0;
  logic first_busy;
  logic [DW-1:0] rv;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic snap();
    rd0 = rd_n;
    wr0 = wr_n;
  endtask

  task automatic cpu_op(input logic we, input logic unc, input int a,
                        input logic [DW-1:0] wd, output logic [DW-1:0] rd);
    int n = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_unc = unc; cpu_addr = AW'(a); cpu_wdata = wd;
    @(negedge clk);
    first_busy = cpu_busy;
    while (!cpu_ack && n < 300) begin @(negedge clk); n++; end
    if (n >= 300) chk("R12 cpu timeout", 0, 1);
    rd = cpu_rdata;
    cpu_req = 0;
  endtask

  task automatic dma_op(input logic we, input int a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd);
    int n = 0;
    @(negedge clk);
    dma_req = 1; dma_we = we; dma_addr = AW'(a); dma_wdata = wd;
    @(negedge clk);
    while (!dma_ack && n < 300) begin @(negedge clk); n++; end
    if (n >= 300) chk("R12 dma timeout", 0, 1);
    rd = dma_rdata;
    dma_req = 0;
  endtask

  task automatic sweep_op();
    int n = 0;
    @(negedge clk);
    sweep_req = 1;
    @(negedge clk);
    while (!sweep_done && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk("R7 sweep timeout", 0, 1);
    sweep_req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R12 watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy", DW'(cpu_busy), 0);
    chk("R1 mem_req", DW'(mem_req), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 serial", DW'(sweep_serial), 0);
    chk("R1 acks", DW'({cpu_ack, dma_ack, sweep_done}), 0);

    // fill every word of tag 0 with stores
    snap();
    cpu_op(1, 0, 0, fw(0), rv);
    chk("R4 miss reads", DW'(rd_n - rd0), 4);
    for (int k = 0; k < 4; k++) chk("R4 fill order", DW'(rlog[rd0 + k]), DW'(k));
    chk("R12 busy during op", DW'(first_busy), 1);
    for (int a = 1; a < 32; a++) cpu_op(1, 0, a, fw(a), rv);
    chk("R2 no mem writes", DW'(wr_n - wr0), 0);
    chk("R4 reads per line", DW'(rd_n - rd0), 32);
    for (int a = 0; a < 32; a++) chk("R2 memory untouched", mm[a], f0(a));

    snap();
    for (int a = 0; a < 32; a++) begin
      cpu_op(0, 0, a, '0, rv);
      chk("R3 read back", rv, fw(a));
    end
    chk("R4 line hits", DW'(rd_n - rd0), 0);

    // R7: sweep writes all modified lines in index order
    snap();
    sweep_op();
    @(negedge clk);
    chk("R7 writes", DW'(wr_n - wr0), 32);
    for (int a = 0; a < 32; a++) chk("R7 order", DW'(wlog[wr0 + a]), DW'(a));
    for (int a = 0; a < 32; a++) chk("R7 memory current", mm[a], fw(a));
    chk("R7 serial", DW'(sweep_serial), 1);

    // R8: lines stay valid and clean
    snap();
    sweep_op();
    @(negedge clk);
    chk("R8 second sweep writes", DW'(wr_n - wr0), 0);
    chk("R8 serial", DW'(sweep_serial), 2);
    cpu_op(0, 0, 5, '0, rv);
    chk("R8 hit data", rv, fw(5));
    chk("R8 hit no reads", DW'(rd_n - rd0), 0);

    // R6: clean conflict
    snap();
    cpu_op(0, 0, 32, '0, rv);
    chk("R6 data", rv, f0(32));
    chk("R6 no writeback", DW'(wr_n - wr0), 0);
    chk("R6 refill", DW'(rd_n - rd0), 4);

    // R5: modified conflict
    cpu_op(1, 0, 9, 36'h1_2345_6789, rv);
    snap();
    cpu_op(0, 0, 41, '0, rv);
    chk("R5 data", rv, f0(41));
    chk("R5 writeback count", DW'(wr_n - wr0), 4);
    for (int k = 0; k < 4; k++) chk("R5 writeback addr", DW'(wlog[wr0 + k]), DW'(8 + k));
    chk("R5 stored word", mm[9], 36'h1_2345_6789);
    chk("R5 refill", DW'(rd_n - rd0), 4);

    // R9: DMA read
    cpu_op(1, 0, 13, 36'hA_BCDE_F012, rv);
    snap();
    dma_op(0, 13, '0, rv);
    chk("R9 cached data", rv, 36'hA_BCDE_F012);
    chk("R9 no traffic", DW'(rd_n - rd0 + wr_n - wr0), 0);
    dma_op(0, 100, '0, rv);
    chk("R9 memory data", rv, f0(100));
    chk("R9 one read", DW'(rd_n - rd0), 1);

    // R10: DMA write invalidates
    snap();
    dma_op(1, 14, 36'h7_7777_0000, rv);
    @(negedge clk);
    chk("R10 memory written", mm[14], 36'h7_7777_0000);
    chk("R10 one write", DW'(wr_n - wr0), 1);
    snap();
    cpu_op(0, 0, 14, '0, rv);
    chk("R10 refetched", rv, 36'h7_7777_0000);
    chk("R10 refill reads", DW'(rd_n - rd0), 4);
    cpu_op(0, 0, 13, '0, rv);
    chk("R10 dropped data", rv, fw(13));

    // R11: uncached
    snap();
    cpu_op(1, 1, 50, 36'h3_1415_9265, rv);
    @(negedge clk);
    chk("R11 memory written", mm[50], 36'h3_1415_9265);
    chk("R11 one write", DW'(wr_n - wr0), 1);
    cpu_op(0, 0, 17, '0, rv);
    chk("R11 slot kept", rv, fw(17));
    chk("R11 no reads", DW'(rd_n - rd0), 0);
    cpu_op(0, 1, 50, '0, rv);
    chk("R11 uncached read", rv, 36'h3_1415_9265);
    chk("R11 one read", DW'(rd_n - rd0), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule